// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Channel

This block turns stereo audio samples from a host into a serial bit stream that follows an external word-select line. The host writes a left sample and then a right sample. When the right sample arrives, the two are committed together as one pair into an internal FIFO. At each frame boundary, when word-select falls from right (1) to left (0) on a bit tick, the block pops one pair. It shifts the left word out during the left slot and the right word during the right slot, most significant bit first.

The serial bit clock and word-select are generated outside the block. They arrive as a one-cycle `bit_tick` strobe and a `ws` level, both synchronous to `clk`. Transmission is gated by three enables: global, transmitter block and channel. The global enable also empties the FIFO when it is low. The block raises a level flag when the FIFO occupancy is at or below a programmed level. It raises a sticky overrun flag when a committed pair is lost because the FIFO is full.

Top module: `i2s_tx_channel`

## Requirements
- R1: After reset, `sd_out` is 0, `empty_flag` is 1 and `overrun` is 0.
- R2: A word-length code c from 0 to 5 selects 12+4c bits per word, and codes 6 and 7 behave as code 5. The word is taken from the low bits of the written sample. On a bit tick where `ws` differs from its value at the previous tick, `sd_out` presents the word's most significant bit one cycle later. Each following tick presents the next lower bit. Every bit after the last word bit in the slot is 0. `ws`=0 is the left slot and `ws`=1 is the right slot.
- R3: `wr_left` stores a pending left sample, and a later `wr_left` replaces it. `wr_right` commits {pending left, right} as one pair only if a left sample is pending. A `wr_right` with no pending left is ignored.
- R4: Pairs leave the FIFO in write order, one pair per frame boundary (a tick where `ws` goes from 1 to 0).
- R5: If the FIFO is empty at a frame boundary, both slots of that frame are all zeros.
- R6: `empty_flag` is 1 exactly when the FIFO occupancy is less than or equal to `empty_lvl`. The level is used with no offset.
- R7: A commit while the FIFO holds DEPTH (16) pairs is dropped and sets `overrun`. The pairs already stored are kept. `overrun` stays set until an `ovr_clr` pulse.
- R8: A channel that becomes active partway through a frame sends zeros until the next frame boundary, and sends the FIFO's next pair from that boundary on. No pair is popped before then.
- R9: While any of `glob_en`, `blk_en` or `ch_en` is low, `sd_out` is 0 from the next cycle and no pair is popped. With only `blk_en` or `ch_en` low, the FIFO contents are kept.
- R10: `glob_en` low empties the FIFO and discards a pending left sample. A `flush` pulse empties the FIFO.
- R11: The FIFO holds up to DEPTH pairs, and its occupancy never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_en | input | 1 | Global enable; low also empties the FIFO |
| blk_en | input | 1 | Transmitter block enable |
| ch_en | input | 1 | Channel enable |
| flush | input | 1 | Empty the FIFO (pulse) |
| word_len | input | 3 | Word-length code, 12+4c bits, capped at code 5 |
| empty_lvl | input | LVL_W (4) | Occupancy level for `empty_flag` |
| wr_left | input | 1 | Write left sample from `wr_data` |
| wr_right | input | 1 | Write right sample and commit the pair |
| wr_data | input | 32 | Sample data for writes |
| ovr_clr | input | 1 | Clear the overrun flag (read strobe) |
| bit_tick | input | 1 | One-cycle strobe per serial bit |
| ws | input | 1 | Word select: 0 left, 1 right |
| sd_out | output | 1 | Serial data |
| empty_flag | output | 1 | Occupancy at or below `empty_lvl` |
| overrun | output | 1 | Sticky flag for a dropped commit |

## Verification
The assertions check, on every cycle, the rules that do not depend on sample values:
- occupancy stays within DEPTH;
- pops happen only at frame boundaries and only from a non-empty FIFO;
- `overrun` rises only on a commit into a full FIFO, and it holds until cleared;
- the output is silent whenever the channel is inactive;
- a global disable leaves the FIFO empty.

Only the bench's scenarios can show the bit order and zero padding for every word-length code, the FIFO ordering, and the two-stage commit with an ignored lone right write. The same holds for the start at the next frame after a mid-frame enable and for the level flag across every level and occupancy.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int SAMPLE_W  = 32;
  localparam int LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_CODE_MAX = 3'd5;
  localparam int LEN_BASE = 12;
  localparam int LEN_STEP = 4;

  // Number of data bits sent per slot for a word-length code.
  function automatic int word_bits(input logic [LEN_CODE_W-1:0] code);
    logic [LEN_CODE_W-1:0] c;
    c = (code > LEN_CODE_MAX) ? LEN_CODE_MAX : code;
    return LEN_BASE + LEN_STEP * int'(c);
  endfunction

  // Place the word's top bit at the MSB of the shift register.
  function automatic logic [SAMPLE_W-1:0] msb_align(input logic [SAMPLE_W-1:0] w,
                                                    input logic [LEN_CODE_W-1:0] code);
    return w << (SAMPLE_W - word_bits(code));
  endfunction

  // Empty-threshold test: occupancy at or below the level.
  function automatic logic level_reached(input int occupancy, input int level);
    return occupancy <= level;
  endfunction
endpackage

// File: rtl/i2s_tx_pair_fifo.sv
module i2s_tx_pair_fifo #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 64,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic               pop,
  output logic [ENTRY_W-1:0] pop_data,
  output logic [CNT_W-1:0]   count,
  output logic               full,
  output logic               empty
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic               do_push, do_pop;

  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);
  assign do_push  = push && !full && !clr;
  assign do_pop   = pop && !empty && !clr;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/i2s_tx_pair_writer.sv
module i2s_tx_pair_writer #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           wr_left,
  input  logic           wr_right,
  input  logic [W-1:0]   wr_data,
  input  logic           fifo_full,
  input  logic           ovr_clr,
  output logic           commit_try,
  output logic           push,
  output logic [2*W-1:0] push_data,
  output logic           overrun
);
  logic [W-1:0] left_hold;
  logic         left_valid;

  assign commit_try = enable && wr_right && left_valid;
  assign push       = commit_try && !fifo_full;
  assign push_data  = {left_hold, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold  <= '0;
      left_valid <= 1'b0;
    end else if (!enable) begin
      left_valid <= 1'b0;
    end else if (wr_left) begin
      left_hold  <= wr_data;
      left_valid <= 1'b1;
    end else if (wr_right) begin
      left_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       overrun <= 1'b0;
    else if (commit_try && fifo_full) overrun <= 1'b1;
    else if (ovr_clr)                 overrun <= 1'b0;
  end
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int W = SAMPLE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic                  bit_tick,
  input  logic                  ws,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  fifo_empty,
  input  logic [2*W-1:0]        pair_data,
  output logic                  frame_start,
  output logic                  pop,
  output logic                  sd_out
);
  logic         ws_q;
  logic         have_pair;
  logic [W-1:0] right_buf;
  logic [W-1:0] shreg;
  logic [W-1:0] load_word;
  logic [W-1:0] aligned;
  logic         slot_start;

  assign slot_start  = bit_tick && (ws != ws_q);
  assign frame_start = slot_start && !ws;
  assign pop         = active && frame_start && !fifo_empty;

  always_comb begin
    if (!ws) load_word = fifo_empty ? '0 : pair_data[2*W-1:W];
    else     load_word = have_pair ? right_buf : '0;
    aligned = msb_align(load_word, len_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ws_q <= 1'b1;
    else if (bit_tick) ws_q <= ws;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_pair <= 1'b0;
      right_buf <= '0;
      shreg     <= '0;
      sd_out    <= 1'b0;
    end else if (!active) begin
      have_pair <= 1'b0;
      right_buf <= '0;
      shreg     <= '0;
      sd_out    <= 1'b0;
    end else if (slot_start) begin
      sd_out <= aligned[W-1];
      shreg  <= aligned << 1;
      if (!ws) begin
        have_pair <= !fifo_empty;
        right_buf <= pair_data[W-1:0];
      end
    end else if (bit_tick) begin
      sd_out <= shreg[W-1];
      shreg  <= shreg << 1;
    end
  end
endmodule

// File: rtl/i2s_tx_channel.sv
module i2s_tx_channel
  import i2s_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  glob_en,
  input  logic                  blk_en,
  input  logic                  ch_en,
  input  logic                  flush,
  input  logic [LEN_CODE_W-1:0] word_len,
  input  logic [LVL_W-1:0]      empty_lvl,
  input  logic                  wr_left,
  input  logic                  wr_right,
  input  logic [SAMPLE_W-1:0]   wr_data,
  input  logic                  ovr_clr,
  input  logic                  bit_tick,
  input  logic                  ws,
  output logic                  sd_out,
  output logic                  empty_flag,
  output logic                  overrun
);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int ENTRY_W = 2 * SAMPLE_W;

  // Named internal events, also observed by the bound checker.
  logic               active;
  logic               fifo_clr;
  logic               commit_try;
  logic               push_evt;
  logic               pop_evt;
  logic               frame_start;
  logic               fifo_full;
  logic               fifo_empty;
  logic [CNT_W-1:0]   fifo_count;
  logic [ENTRY_W-1:0] push_data;
  logic [ENTRY_W-1:0] head_pair;

  assign active     = glob_en && blk_en && ch_en;
  assign fifo_clr   = flush || !glob_en;
  assign empty_flag = level_reached(int'(fifo_count), int'(empty_lvl));

  i2s_tx_pair_writer #(.W(SAMPLE_W)) u_writer (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (glob_en),
    .wr_left    (wr_left),
    .wr_right   (wr_right),
    .wr_data    (wr_data),
    .fifo_full  (fifo_full),
    .ovr_clr    (ovr_clr),
    .commit_try (commit_try),
    .push       (push_evt),
    .push_data  (push_data),
    .overrun    (overrun)
  );

  i2s_tx_pair_fifo #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_clr),
    .push      (push_evt),
    .push_data (push_data),
    .pop       (pop_evt),
    .pop_data  (head_pair),
    .count     (fifo_count),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  i2s_tx_serializer #(.W(SAMPLE_W)) u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active),
    .bit_tick    (bit_tick),
    .ws          (ws),
    .len_code    (word_len),
    .fifo_empty  (fifo_empty),
    .pair_data   (head_pair),
    .frame_start (frame_start),
    .pop         (pop_evt),
    .sd_out      (sd_out)
  );
endmodule

// File: rtl/i2s_tx_channel_chk.sv
module i2s_tx_channel_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glob_en,
  input logic             blk_en,
  input logic             ch_en,
  input logic             ovr_clr,
  input logic             sd_out,
  input logic             empty_flag,
  input logic             overrun,
  input logic [CNT_W-1:0] fifo_count,
  input logic             pop_evt,
  input logic             frame_start,
  input logic             commit_try,
  input logic             fifo_full
);
  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_count) <= DEPTH);

  assert_pop_at_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> frame_start);

  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> fifo_count != '0);

  assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(commit_try && fifo_full));

  assert_overrun_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  assert_quiet_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(glob_en && blk_en && ch_en) |=> !sd_out);

  assert_global_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> fifo_count == '0);

  assert_empty_flag_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count == '0 |-> empty_flag);
endmodule

bind i2s_tx_channel i2s_tx_channel_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .glob_en     (glob_en),
  .blk_en      (blk_en),
  .ch_en       (ch_en),
  .ovr_clr     (ovr_clr),
  .sd_out      (sd_out),
  .empty_flag  (empty_flag),
  .overrun     (overrun),
  .fifo_count  (fifo_count),
  .pop_evt     (pop_evt),
  .frame_start (frame_start),
  .commit_try  (commit_try),
  .fifo_full   (fifo_full)
);

// File: tb/i2s_tx_channel_bench.sv
`timescale 1ns/1ps
module i2s_tx_channel_bench;
  localparam int DEPTH = 16;
  localparam int SLOT  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glob_en = 1'b0, blk_en = 1'b0, ch_en = 1'b0, flush = 1'b0;
  logic [2:0]  word_len = 3'd5;
  logic [3:0]  empty_lvl = 4'd8;
  logic        wr_left = 1'b0, wr_right = 1'b0, ovr_clr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        bit_tick = 1'b1, ws = 1'b1;
  logic        sd_out, empty_flag, overrun;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2s_tx_channel u_i2s_tx_channel (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .blk_en(blk_en), .ch_en(ch_en),
    .flush(flush), .word_len(word_len), .empty_lvl(empty_lvl),
    .wr_left(wr_left), .wr_right(wr_right), .wr_data(wr_data), .ovr_clr(ovr_clr),
    .bit_tick(bit_tick), .ws(ws), .sd_out(sd_out), .empty_flag(empty_flag),
    .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [31:0] l, input logic [31:0] r,
                                            input int code);
    int n;
    int res;
    logic [63:0] e;
    n = (code > 5) ? 5 : code;
    res = 12 + 4 * n;
    e = '0;
    for (int i = 0; i < SLOT; i++) begin
      if (i < res) begin
        e[i]        = l[res-1-i];
        e[SLOT + i] = r[res-1-i];
      end
    end
    return e;
  endfunction

  task automatic push_pair(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk); wr_left = 1'b1; wr_data = l;
    @(negedge clk); wr_left = 1'b0; wr_right = 1'b1; wr_data = r;
    @(negedge clk); wr_right = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  // got[i] is sd_out after the tick at frame cycle i (left slot 0..31, right 32..63).
  task automatic run_frame(input int en_at, output logic [63:0] got);
    for (int i = 0; i < 2 * SLOT; i++) begin
      @(negedge clk);
      ws = (i >= SLOT);
      if (i == en_at) ch_en = 1'b1;
      @(posedge clk); #1;
      got[i] = sd_out;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] got;
    logic [31:0] lv, rv;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sd_out == 1'b0, "R1 sd_out", {63'd0, sd_out}, 64'd0);
    check(empty_flag == 1'b1, "R1 empty_flag", {63'd0, empty_flag}, 64'd1);
    check(overrun == 1'b0, "R1 overrun", {63'd0, overrun}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    glob_en = 1'b1; blk_en = 1'b1; ch_en = 1'b1;

    // R2: every word-length code, including the capped ones
    for (int c = 0; c < 8; c++) begin
      word_len = 3'(c);
      lv = 32'hA5C3_96E1 ^ (32'h1111_1111 * c);
      rv = 32'h5E2B_7D94 + 32'h0F0F_0101 * c;
      push_pair(lv, rv);
      run_frame(-1, got);
      check(got == exp_frame(lv, rv, c), $sformatf("R2 code %0d", c), got, exp_frame(lv, rv, c));
    end
    word_len = 3'd5;

    // R5: empty FIFO gives a zero frame
    run_frame(-1, got);
    check(got == '0, "R5 empty frame", got, '0);

    // R4: order of several pairs
    for (int k = 0; k < 3; k++) push_pair(32'h1000_0000 + k, 32'h2000_0000 + k);
    for (int k = 0; k < 3; k++) begin
      run_frame(-1, got);
      check(got == exp_frame(32'h1000_0000 + k, 32'h2000_0000 + k, 5), "R4 order", got,
            exp_frame(32'h1000_0000 + k, 32'h2000_0000 + k, 5));
    end

    // R3: lone right write ignored; second left replaces first
    @(negedge clk); wr_right = 1'b1; wr_data = 32'hDEAD_BEEF;
    @(negedge clk); wr_right = 1'b0;
    run_frame(-1, got);
    check(got == '0, "R3 lone right ignored", got, '0);
    @(negedge clk); wr_left = 1'b1; wr_data = 32'h1111_2222;
    @(negedge clk); wr_data = 32'h3333_4444;
    @(negedge clk); wr_left = 1'b0; wr_right = 1'b1; wr_data = 32'h5555_6666;
    @(negedge clk); wr_right = 1'b0;
    run_frame(-1, got);
    check(got == exp_frame(32'h3333_4444, 32'h5555_6666, 5), "R3 left replaced", got,
          exp_frame(32'h3333_4444, 32'h5555_6666, 5));

    // R6: every level against every occupancy 0..DEPTH
    for (int lvl = 0; lvl < 16; lvl++) begin
      empty_lvl = 4'(lvl);
      pulse_flush();
      #1;
      check(empty_flag == 1'b1, $sformatf("R6 lvl %0d occ 0", lvl), {63'd0, empty_flag}, 64'd1);
      for (int k = 1; k <= DEPTH; k++) begin
        push_pair(32'(k), 32'(k));
        #1;
        check(empty_flag == (k <= lvl), $sformatf("R6 lvl %0d occ %0d", lvl, k),
              {63'd0, empty_flag}, {63'd0, (k <= lvl)});
      end
    end
    empty_lvl = 4'd8;
    pulse_flush();

    // R7 and R11: fill to capacity, overflow, clear, drain
    for (int k = 0; k < DEPTH; k++) push_pair(32'hC000_0000 + k, 32'hD000_0000 + k);
    #1;
    check(overrun == 1'b0, "R11 full without overrun", {63'd0, overrun}, 64'd0);
    push_pair(32'hEEEE_EEEE, 32'hFFFF_FFFF);
    #1;
    check(overrun == 1'b1, "R7 overrun set", {63'd0, overrun}, 64'd1);
    repeat (3) @(negedge clk);
    check(overrun == 1'b1, "R7 overrun sticky", {63'd0, overrun}, 64'd1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    check(overrun == 1'b0, "R7 overrun cleared", {63'd0, overrun}, 64'd0);
    for (int k = 0; k < DEPTH; k++) begin
      run_frame(-1, got);
      check(got == exp_frame(32'hC000_0000 + k, 32'hD000_0000 + k, 5), "R11 drain", got,
            exp_frame(32'hC000_0000 + k, 32'hD000_0000 + k, 5));
    end
    run_frame(-1, got);
    check(got == '0, "R7 dropped pair absent", got, '0);

    // R8: enable mid-frame starts at next frame boundary
    ch_en = 1'b0;
    push_pair(32'h0ABC_DEF1, 32'h0246_8ACE);
    run_frame(5, got);
    check(got == '0, "R8 mid-frame enable silent", got, '0);
    run_frame(-1, got);
    check(got == exp_frame(32'h0ABC_DEF1, 32'h0246_8ACE, 5), "R8 next frame", got,
          exp_frame(32'h0ABC_DEF1, 32'h0246_8ACE, 5));

    // R9: block disable silences and keeps the FIFO
    blk_en = 1'b0;
    push_pair(32'h7777_1234, 32'h8888_5678);
    run_frame(-1, got);
    check(got == '0, "R9 block disabled silent", got, '0);
    blk_en = 1'b1;
    run_frame(-1, got);
    check(got == exp_frame(32'h7777_1234, 32'h8888_5678, 5), "R9 FIFO kept", got,
          exp_frame(32'h7777_1234, 32'h8888_5678, 5));

    // R10: global disable flushes FIFO and pending left; flush input
    push_pair(32'h1357_9BDF, 32'h2468_ACE0);
    @(negedge clk); glob_en = 1'b0;
    @(negedge clk); glob_en = 1'b1;
    run_frame(-1, got);
    check(got == '0, "R10 global disable flush", got, '0);
    @(negedge clk); wr_left = 1'b1; wr_data = 32'h4242_4242;
    @(negedge clk); wr_left = 1'b0; glob_en = 1'b0;
    @(negedge clk); glob_en = 1'b1;
    @(negedge clk); wr_right = 1'b1; wr_data = 32'h2424_2424;
    @(negedge clk); wr_right = 1'b0;
    run_frame(-1, got);
    check(got == '0, "R10 pending left discarded", got, '0);
    push_pair(32'h9999_0000, 32'h0000_9999);
    pulse_flush();
    run_frame(-1, got);
    check(got == '0, "R10 flush input", got, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule